// File: doc/BRIEF.md
# Serial Memory Write-Protect Controller

This block owns the status register of a small serial memory with a 14-bit address space. It decides, in the same cycle a request arrives, whether each array write or status write may proceed. The decision combines three things: a software write-enable latch, a two-bit block-protection field that covers the top quarter, the top half or the whole array, and an active-low hardware protect pin. The pin only takes effect when an enable bit in the status register is set, and while it is in effect the status register cannot be changed.

Command decoding happens upstream and arrives as one-cycle strobes. A grant tells the write engine to start. The engine's busy flag is shown as the ready bit and marks the end of the write cycle. The block-protection bits and the pin-enable bit model nonvolatile cells. The logic reset leaves them untouched, and their power-up contents are undefined until the first status write.

Top module: `spi_wprot_ctrl`

## Requirements
- R1: The status byte has the pin-enable bit at bit 7, block-protect bits 1:0 at bits 3:2, the write-enable latch at bit 1 and the ready flag at bit 0. Bits 6 to 4 always read 0.
- R2: Status bit 0 equals busy_i in the same cycle. No status write affects it.
- R3: A write-enable strobe sets the latch and a write-disable strobe clears it, both visible in the next cycle. If both strobes arrive together, the latch ends up cleared.
- R4: The block-protect field selects the protected range: 00 none, 01 addresses 0x3000 to 0x3FFF, 10 addresses 0x2000 to 0x3FFF, 11 the whole array. An array write to a protected address is always rejected.
- R5: An array write to an unprotected address is granted in its request cycle only when the latch is 1 and busy_i is 0. Otherwise it is rejected.
- R6: Hardware protection is active exactly when wp_ni is 0 and the pin-enable bit is 1. It blocks status writes but does not block array writes to unprotected addresses.
- R7: A status write is granted only when the latch is 1, busy_i is 0 and hardware protection is off. A granted write loads data bit 7 into the pin-enable bit and data bits 3:2 into the protect field, visible from the next cycle. All other data bits are ignored.
- R8: Any array or status request made while busy_i is 1 is rejected.
- R9: A rejected request pulses its reject output for its own cycle only and leaves the whole status byte unchanged. For every request exactly one of grant or reject is high.
- R10: After a granted write, the latch clears in the cycle after the first 1-to-0 transition of busy_i.
- R11: Reset clears the latch and the end-of-write tracking. The protect field and the pin-enable bit keep their values across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low logic reset |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| wrsr_i | input | 1 | Status-write command strobe |
| wrsr_data_i | input | 8 | Data byte of the status write |
| mem_wr_i | input | 1 | Array write request strobe |
| mem_addr_i | input | 14 | Array write address |
| busy_i | input | 1 | Write engine busy flag |
| wp_ni | input | 1 | Hardware write-protect pin, active low |
| status_o | output | 8 | Readable status byte |
| mem_grant_o | output | 1 | Array write accepted |
| mem_reject_o | output | 1 | Array write refused |
| sr_grant_o | output | 1 | Status write accepted |
| sr_reject_o | output | 1 | Status write refused |

## Verification
Every piece of internal state is visible in the status byte, so a wrong latch, protect field or pin-enable value shows up on status_o one cycle after the edge that corrupted it. It also flips the grant or reject of the next request that depends on it. A stuck end-of-write tracker is the only slower fault: it shows up as a latch that stays set, or clears early, around the busy edge that follows a granted write. The bench compares the full port state against its own model on every cycle. It sweeps each protect mode across boundary addresses and every pin and enable combination.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;

  localparam int unsigned STAT_W = 8;

  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_mode_e;

  typedef struct packed {
    logic       pin_en;
    logic [2:0] rsvd;
    bp_mode_e   bp;
    logic       wel;
    logic       busy;
  } wp_status_t;

endpackage

// File: rtl/wp_range_dec.sv
module wp_range_dec
  import spi_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  bp_mode_e          bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);

  localparam int unsigned NMODE = 4;

  logic [NMODE-1:0] hit;

  // one comparator per protect mode, lower bound of the protected top region
  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    if (m == 0) begin : g_none
      assign hit[m] = 1'b0;
    end else if (m == NMODE - 1) begin : g_all
      assign hit[m] = 1'b1;
    end else begin : g_part
      localparam logic [ADDR_W:0] BASE =
        (m == 1) ? ((ADDR_W+1)'(3) << (ADDR_W - 2)) : ((ADDR_W+1)'(1) << (ADDR_W - 1));
      assign hit[m] = ({1'b0, addr_i} >= BASE);
    end
  end

  assign prot_o = hit[bp_i];

endmodule

// File: rtl/wp_nv_bits.sv
module wp_nv_bits
  import spi_wp_pkg::*;
(
  input  logic     clk_i,
  input  logic     wr_en_i,
  input  logic     pin_en_d_i,
  input  bp_mode_e bp_d_i,
  output logic     pin_en_o,
  output bp_mode_e bp_o
);

  // models nonvolatile cells: deliberately outside the logic reset
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      pin_en_o <= pin_en_d_i;
      bp_o     <= bp_d_i;
    end
  end

endmodule

// File: rtl/wp_wel_ctrl.sv
module wp_wel_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic grant_i,
  input  logic busy_i,
  output logic wel_o
);

  logic pend_q, busy_q, wr_done;

  // first busy falling edge after an accepted write
  assign wr_done = pend_q & busy_q & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      wel_o  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (grant_i)      pend_q <= 1'b1;
      else if (wr_done) pend_q <= 1'b0;
      if (wrdi_i)       wel_o <= 1'b0;
      else if (wren_i)  wel_o <= 1'b1;
      else if (wr_done) wel_o <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_wprot_ctrl.sv
module spi_wprot_ctrl
  import spi_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [STAT_W-1:0] wrsr_data_i,
  input  logic              mem_wr_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic              busy_i,
  input  logic              wp_ni,
  output logic [STAT_W-1:0] status_o,
  output logic              mem_grant_o,
  output logic              mem_reject_o,
  output logic              sr_grant_o,
  output logic              sr_reject_o
);

  logic       wel, pin_en, addr_prot, hw_lock, mem_ok, sr_ok;
  bp_mode_e   bp;
  wp_status_t stat;
  logic       unused_data;

  assign unused_data = ^{wrsr_data_i[6:4], wrsr_data_i[1:0]};

  wp_range_dec #(.ADDR_W(ADDR_W)) u_range (
    .bp_i   (bp),
    .addr_i (mem_addr_i),
    .prot_o (addr_prot)
  );

  wp_nv_bits u_nv (
    .clk_i      (clk_i),
    .wr_en_i    (sr_ok),
    .pin_en_d_i (wrsr_data_i[7]),
    .bp_d_i     (bp_mode_e'(wrsr_data_i[3:2])),
    .pin_en_o   (pin_en),
    .bp_o       (bp)
  );

  wp_wel_ctrl u_wel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wren_i  (wren_i),
    .wrdi_i  (wrdi_i),
    .grant_i (mem_ok | sr_ok),
    .busy_i  (busy_i),
    .wel_o   (wel)
  );

  assign hw_lock = pin_en & ~wp_ni;
  assign mem_ok  = mem_wr_i & ~busy_i & wel & ~addr_prot;
  assign sr_ok   = wrsr_i & ~busy_i & wel & ~hw_lock;

  assign mem_grant_o  = mem_ok;
  assign mem_reject_o = mem_wr_i & ~mem_ok;
  assign sr_grant_o   = sr_ok;
  assign sr_reject_o  = wrsr_i & ~sr_ok;

  always_comb begin
    stat.pin_en = pin_en;
    stat.rsvd   = '0;
    stat.bp     = bp;
    stat.wel    = wel;
    stat.busy   = busy_i;
  end
  assign status_o = stat;

endmodule

// File: rtl/spi_wprot_ctrl_chk.sv
module spi_wprot_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wren_i,
  input logic       wrdi_i,
  input logic       wrsr_i,
  input logic       mem_wr_i,
  input logic [1:0] sr_bp_i,
  input logic       sr_pin_en_i,
  input logic       busy_i,
  input logic       wp_ni,
  input logic [7:0] status_i,
  input logic       mem_grant_i,
  input logic       mem_reject_i,
  input logic       sr_grant_i,
  input logic       sr_reject_i
);

  assert_unused_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[6:4] == 3'b000);

  assert_ready_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[0] == busy_i);

  assert_wren_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wren_i && !wrdi_i) |=> status_i[1]);

  assert_wrdi_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrdi_i |=> !status_i[1]);

  assert_full_protect_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_grant_i |-> status_i[3:2] != 2'b11);

  assert_mem_needs_wel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_grant_i |-> status_i[1]);

  assert_hw_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_grant_i |-> !(status_i[7] && !wp_ni) && status_i[1]);

  assert_sr_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_grant_i |=> (status_i[3:2] == $past(sr_bp_i)) && (status_i[7] == $past(sr_pin_en_i)));

  assert_busy_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !mem_grant_i && !sr_grant_i);

  assert_no_sr_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_grant_i |=> $stable(status_i[7:2]));

  assert_mem_one_of_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_i == (mem_grant_i ^ mem_reject_i) && !(mem_grant_i && mem_reject_i));

  assert_sr_one_of_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrsr_i == (sr_grant_i ^ sr_reject_i) && !(sr_grant_i && sr_reject_i));

endmodule

bind spi_wprot_ctrl spi_wprot_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wren_i       (wren_i),
  .wrdi_i       (wrdi_i),
  .wrsr_i       (wrsr_i),
  .mem_wr_i     (mem_wr_i),
  .sr_bp_i      (wrsr_data_i[3:2]),
  .sr_pin_en_i  (wrsr_data_i[7]),
  .busy_i       (busy_i),
  .wp_ni        (wp_ni),
  .status_i     (status_o),
  .mem_grant_i  (mem_grant_o),
  .mem_reject_i (mem_reject_o),
  .sr_grant_i   (sr_grant_o),
  .sr_reject_i  (sr_reject_o)
);

// File: tb/spi_wprot_ctrl_test.sv
`timescale 1ns/1ps
module spi_wprot_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wren = 0, wrdi = 0, wrsr = 0, mwr = 0, busy = 0, wp_n = 1;
  logic [7:0]  sdata = '0;
  logic [13:0] addr = '0;
  logic [7:0]  status;
  logic        mg, mr, sg, sr;

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  string cur_tag = "R11";

  // behavioural reference state
  bit       m_wel = 0, m_pin = 0, m_pend = 0, m_bprev = 0, nv_known = 0;
  bit [1:0] m_bp = 0;

  always #10 clk = ~clk;

  spi_wprot_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr),
    .wrsr_data_i(sdata), .mem_wr_i(mwr), .mem_addr_i(addr), .busy_i(busy),
    .wp_ni(wp_n), .status_o(status), .mem_grant_o(mg), .mem_reject_o(mr),
    .sr_grant_o(sg), .sr_reject_o(sr)
  );

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp, logic [7:0] mask);
    n_chk++;
    if ((act & mask) !== (exp & mask)) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act & mask, exp & mask);
    end
  endtask

  function automatic bit prot(bit [1:0] bp, bit [13:0] a);
    case (bp)
      2'd0: return 0;
      2'd1: return a >= 14'h3000;
      2'd2: return a >= 14'h2000;
      default: return 1;
    endcase
  endfunction

  task automatic compare_now();
    bit       e_mg, e_sg, hw;
    bit [7:0] e_st;
    hw   = m_pin && !wp_n;
    e_mg = mwr && !busy && m_wel && !prot(m_bp, addr);
    e_sg = wrsr && !busy && m_wel && !hw;
    e_st = {m_pin, 3'b000, m_bp, m_wel, busy};
    chk("status", status, e_st, nv_known ? 8'hFF : 8'h73);
    chk("mem_grant", {7'd0, mg}, {7'd0, e_mg}, 8'h01);
    chk("mem_reject", {7'd0, mr}, {7'd0, mwr && !e_mg}, 8'h01);
    chk("sr_grant", {7'd0, sg}, {7'd0, e_sg}, 8'h01);
    chk("sr_reject", {7'd0, sr}, {7'd0, wrsr && !e_sg}, 8'h01);
  endtask

  task automatic cyc(bit en, bit dis, bit sw, bit [7:0] d, bit mw, bit [13:0] a, bit bz);
    bit e_mg, e_sg, fin;
    wren = en; wrdi = dis; wrsr = sw; sdata = d; mwr = mw; addr = a; busy = bz;
    #5;
    compare_now();
    e_mg = mw && !bz && m_wel && !prot(m_bp, a);
    e_sg = sw && !bz && m_wel && !(m_pin && !wp_n);
    fin  = m_pend && m_bprev && !bz;
    if (e_sg) begin m_pin = d[7]; m_bp = d[3:2]; end
    if (e_mg || e_sg) m_pend = 1; else if (fin) m_pend = 0;
    if (dis) m_wel = 0; else if (en) m_wel = 1; else if (fin) m_wel = 0;
    m_bprev = bz;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n, bit bz);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00, 0, 14'h0, bz);
  endtask
  task automatic do_wren();  cyc(1, 0, 0, 8'h00, 0, 14'h0, 0); endtask
  task automatic do_wrdi();  cyc(0, 1, 0, 8'h00, 0, 14'h0, 0); endtask
  task automatic do_wrsr(bit [7:0] d); cyc(0, 0, 1, d, 0, 14'h0, 0); endtask
  task automatic do_mwr(bit [13:0] a); cyc(0, 0, 0, 8'h00, 1, a, 0); endtask
  task automatic finish_write(); idle(2, 1); idle(2, 0); endtask

  task automatic reset_pulse();
    rst_n = 0;
    wren = 0; wrdi = 0; wrsr = 0; mwr = 0; busy = 0;
    m_wel = 0; m_pend = 0; m_bprev = 0;
    #5;
    compare_now();
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic set_bp(bit [7:0] d);
    do_wren(); do_wrsr(d); finish_write();
  endtask

  initial begin
    @(negedge clk);
    cur_tag = "R11";
    reset_pulse();
    idle(1, 0);

    cur_tag = "R7";
    do_wren(); do_wrsr(8'h00); nv_known = 1;
    cur_tag = "R10";
    finish_write();

    cur_tag = "R1";
    do_wren(); do_wrsr(8'hFF); idle(1, 0);
    cur_tag = "R2";
    idle(1, 1);
    cur_tag = "R8";
    cyc(1, 0, 0, 8'h00, 0, 14'h0, 1);
    cyc(0, 0, 0, 8'h00, 1, 14'h0100, 1);
    cyc(0, 0, 1, 8'h00, 0, 14'h0, 1);
    cur_tag = "R10";
    idle(2, 0);

    cur_tag = "R4";
    for (int b = 0; b < 4; b++) begin
      set_bp({4'b0000, 2'(b), 2'b00});
      do_wren();
      do_mwr(14'h0000); do_mwr(14'h1FFF); do_mwr(14'h2000);
      do_mwr(14'h2FFF); do_mwr(14'h3000); do_mwr(14'h3FFF);
      finish_write();
    end

    cur_tag = "R5";
    set_bp(8'h00);
    do_wrdi(); do_mwr(14'h0100);
    do_wren(); do_mwr(14'h0100); finish_write();

    cur_tag = "R9";
    do_wrdi(); do_wrsr(8'hFF); do_mwr(14'h0200); idle(1, 0);

    cur_tag = "R6";
    set_bp(8'h80);
    wp_n = 0;
    do_wren(); do_wrsr(8'h0C); do_mwr(14'h3FFF); finish_write();
    wp_n = 1;
    do_wren(); do_wrsr(8'h88); finish_write();
    wp_n = 0;
    do_wren(); do_mwr(14'h2000); do_mwr(14'h1000); do_wrsr(8'h00); finish_write();
    wp_n = 1;
    set_bp(8'h00);
    wp_n = 0;
    do_wren(); do_wrsr(8'h04); finish_write();
    wp_n = 1;

    cur_tag = "R3";
    do_wren(); idle(1, 0); do_wrdi(); idle(1, 0);
    do_wren(); cyc(1, 1, 0, 8'h00, 0, 14'h0, 0); idle(1, 0);

    cur_tag = "R11";
    set_bp(8'h88);
    do_wren();
    reset_pulse();
    idle(2, 0);
    do_mwr(14'h0010);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule